// File: doc/BRIEF.md
# Status Output Pin Selector

This block drives the single open-drain status pin of a serially programmed frequency synthesizer. A 3-bit selection code chooses what the pin reports when the serial port is idle. The pin can be released (high impedance). It can be pulled low while the loop reports an unlock. It can carry a sticky count-finished flag. It can mirror the level of one of two general-purpose I/O pins. The output is a single active-high drive-low enable: 0 means the pin is released and 1 means the pin is pulled low.

Serial activity always wins over the selection code. While chip-enable is high and the port is receiving, the pin stays released. While chip-enable is high and the port is transmitting, the pin presents the shift-out bit. That bit is captured on each rising edge of the serial clock, and the pin is released from the start of the transfer until the first such edge.

In count-finished mode, a flag register holds the low state. A completion pulse sets the flag. A 0-to-1 step of the counter start bit clears it, and so does the rising edge of chip-enable. A clear wins over a set in the same cycle.

All inputs are sampled on the rising clock edge. The pull-low enable is a register, and it reflects the inputs of that edge.

Top module: `status_pin_sel`

## Requirements
- R1: While reset is asserted, and immediately after it, pull_low is 0 (pin released).
- R2: With chip_en low, the codes 3'b000, 3'b011, 3'b100 and 3'b111 give pull_low = 0 whatever the other inputs are.
- R3: With chip_en low and code 3'b001, pull_low after a clock edge equals the unlock input sampled at that edge.
- R4: With chip_en low and code 3'b010, pull_low shows a sticky flag. A cnt_done pulse sets the flag. A 0-to-1 step of cnt_start clears it. When both occur at the same edge, the clear wins.
- R5: A rising edge of chip_en clears the count-finished flag, so after the transfer code 3'b010 shows a released pin.
- R6: With chip_en low, code 3'b101 gives pull_low = NOT io_level[0] and code 3'b110 gives pull_low = NOT io_level[1], provided that the I/O pin is an input (io_is_out bit = 0).
- R7: When the I/O pin chosen by code 3'b101 or 3'b110 has its io_is_out bit set, pull_low is 0.
- R8: While chip_en is high and xfer_out_mode is 0 (receive), pull_low is 0 for every code.
- R9: While chip_en is high and xfer_out_mode is 1 (transmit), pull_low = NOT the shift_bit captured at the latest rising edge of ser_clk. Before the first such edge in the transfer, pull_low is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_code | input | 3 | Source selection code |
| chip_en | input | 1 | Serial chip-enable, high during a transfer |
| ser_clk | input | 1 | Serial clock level |
| xfer_out_mode | input | 1 | 1 = transmit transfer, 0 = receive transfer |
| shift_bit | input | 1 | Current shift-out data bit |
| unlock | input | 1 | Loop unlock indication |
| cnt_start | input | 1 | Counter start control bit |
| cnt_done | input | 1 | Single-cycle counter completion pulse |
| io_level | input | 2 | Levels of the two general I/O pins |
| io_is_out | input | 2 | 1 = the matching I/O pin is configured as an output |
| pull_low | output | 1 | Drive-low enable for the status pin |

## Verification
A wrong count-finished flag shows only under code 3'b010, and it shows one edge after the event. A flag that missed its set stays released. A flag that missed its clear stays low until a later start step or transfer. For this reason the bench sets and clears the flag on every clear path, including a clear and a set at the same edge. A stale captured shift bit shows up in transmit mode as a wrong level one edge after the serial clock rises. It also shows up at the start of a new transfer if the capture is not reset to released. Both transfer directions are therefore run, and a transfer follows one that left a 0 captured.

// File: rtl/status_pin_pkg.sv
package status_pin_pkg;
    localparam int CODE_W  = 3;
    localparam int IO_BASE = 5;

    typedef enum logic [CODE_W-1:0] {
        SRC_OFF_0  = 3'd0,
        SRC_UNLOCK = 3'd1,
        SRC_COUNT  = 3'd2,
        SRC_OFF_3  = 3'd3,
        SRC_OFF_4  = 3'd4,
        SRC_IO_A   = 3'd5,
        SRC_IO_B   = 3'd6,
        SRC_OFF_7  = 3'd7
    } src_code_e;

    typedef struct packed {
        logic pull_low;
        logic sdo;
    } pin_state_t;
endpackage

// File: rtl/sp_edge_track.sv
module sp_edge_track #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
        rise   = sig & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sp_count_flag.sv
module sp_count_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rise,
    input  logic ce_rise,
    input  logic done,
    output logic flag_d,
    output logic flag_q
);
    always_comb begin
        flag_d = flag_q;
        if (start_rise || ce_rise) flag_d = 1'b0;
        else if (done)             flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    // R5
    ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_rise |=> !flag_q);
    // R4
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_rise && !ce_rise) |=> flag_q);
    // R4
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rise |=> !flag_q);
endmodule

// File: rtl/sp_src_mux.sv
module sp_src_mux
    import status_pin_pkg::*;
#(
    parameter int NUM_IO = 2
) (
    input  logic [CODE_W-1:0] code,
    input  logic              unlock,
    input  logic              flag_next,
    input  logic [NUM_IO-1:0] io_level,
    input  logic [NUM_IO-1:0] io_is_out,
    output logic              sel_pull
);
    logic [NUM_IO-1:0] io_pull;

    for (genvar k = 0; k < NUM_IO; k++) begin : g_io
        assign io_pull[k] = ~io_level[k] & ~io_is_out[k];
    end

    always_comb begin
        sel_pull = 1'b0;
        if (code == SRC_UNLOCK)     sel_pull = unlock;
        else if (code == SRC_COUNT) sel_pull = flag_next;
        for (int k = 0; k < NUM_IO; k++) begin
            if (code == CODE_W'(IO_BASE + k)) sel_pull = io_pull[k];
        end
    end
endmodule

// File: rtl/status_pin_sel.sv
module status_pin_sel
    import status_pin_pkg::*;
#(
    parameter int NUM_IO = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel_code,
    input  logic              chip_en,
    input  logic              ser_clk,
    input  logic              xfer_out_mode,
    input  logic              shift_bit,
    input  logic              unlock,
    input  logic              cnt_start,
    input  logic              cnt_done,
    input  logic [NUM_IO-1:0] io_level,
    input  logic [NUM_IO-1:0] io_is_out,
    output logic              pull_low
);
    localparam int EDGE_W = 3;

    logic [EDGE_W-1:0] rises;
    logic sclk_rise, ce_rise, start_rise;
    logic flag_next, flag_now, sel_pull;
    pin_state_t st_d, st_q;

    sp_edge_track #(.W(EDGE_W)) edge_i (
        .clk(clk), .rst_n(rst_n),
        .sig({cnt_start, chip_en, ser_clk}),
        .rise(rises)
    );
    assign sclk_rise  = rises[0];
    assign ce_rise    = rises[1];
    assign start_rise = rises[2];

    sp_count_flag flag_i (
        .clk(clk), .rst_n(rst_n),
        .start_rise(start_rise), .ce_rise(ce_rise), .done(cnt_done),
        .flag_d(flag_next), .flag_q(flag_now)
    );

    sp_src_mux #(.NUM_IO(NUM_IO)) mux_i (
        .code(sel_code), .unlock(unlock), .flag_next(flag_next),
        .io_level(io_level), .io_is_out(io_is_out), .sel_pull(sel_pull)
    );

    always_comb begin
        st_d = st_q;
        if (ce_rise)   st_d.sdo = 1'b1;
        if (sclk_rise) st_d.sdo = shift_bit;
        if (chip_en) st_d.pull_low = xfer_out_mode ? ~st_d.sdo : 1'b0;
        else         st_d.pull_low = sel_pull;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pull_low: 1'b0, sdo: 1'b1};
        else        st_q <= st_d;
    end

    assign pull_low = st_q.pull_low;

    // R8
    rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && !xfer_out_mode) |=> !pull_low);
    // R2
    off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && (sel_code == SRC_OFF_0 || sel_code == SRC_OFF_3 ||
                      sel_code == SRC_OFF_4 || sel_code == SRC_OFF_7)) |=> !pull_low);
    // R3
    unlock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && sel_code == SRC_UNLOCK) |=> (pull_low == $past(unlock)));
    // R7
    io_out_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && sel_code == SRC_IO_A && io_is_out[0]) |=> !pull_low);
    // R9
    tx_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && xfer_out_mode && sclk_rise) |=> (pull_low == !$past(shift_bit)));
    // R4
    count_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && sel_code == SRC_COUNT) |=> (pull_low == flag_now));
endmodule

// File: tb/status_pin_sel_tb_top.sv
`timescale 1ns/1ps
module status_pin_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel_code = 3'd0;
    logic       chip_en = 1'b0, ser_clk = 1'b0, xfer_out_mode = 1'b0, shift_bit = 1'b0;
    logic       unlock = 1'b0, cnt_start = 1'b0, cnt_done = 1'b0;
    logic [1:0] io_level = 2'b11, io_is_out = 2'b00;
    logic       pull_low;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    status_pin_sel dut_i (
        .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .chip_en(chip_en),
        .ser_clk(ser_clk), .xfer_out_mode(xfer_out_mode), .shift_bit(shift_bit),
        .unlock(unlock), .cnt_start(cnt_start), .cnt_done(cnt_done),
        .io_level(io_level), .io_is_out(io_is_out), .pull_low(pull_low)
    );

    task automatic check_now(input logic exp, input string tag);
        total++;
        if (pull_low !== exp) begin
            bad++;
            $display("FAIL %s: pull_low=%b expected=%b", tag, pull_low, exp);
        end
    endtask

    // driver: inputs are already set at a falling edge; queue the expected result
    task automatic step(input logic exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // monitor: compare just after every rising edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check_now(it.exp, it.tag);
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        unlock = 1'b1;
        repeat (3) @(negedge clk);
        check_now(1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_now(1'b0, "R1 after reset");
        @(negedge clk);

        // R2: released codes with every source active
        io_level = 2'b00;
        sel_code = 3'd0; step(1'b0, "R2 code0");
        sel_code = 3'd3; step(1'b0, "R2 code3");
        sel_code = 3'd4; step(1'b0, "R2 code4");
        sel_code = 3'd7; step(1'b0, "R2 code7");
        io_level = 2'b11;

        // R3: unlock follow
        sel_code = 3'd1; unlock = 1'b1; step(1'b1, "R3 unlock high");
        unlock = 1'b0; step(1'b0, "R3 unlock low");
        unlock = 1'b1; step(1'b1, "R3 unlock high again");

        // R4: count-finished flag
        sel_code = 3'd2; step(1'b0, "R4 flag idle");
        cnt_start = 1'b1; step(1'b0, "R4 start rise");
        cnt_done = 1'b1; step(1'b1, "R4 done sets");
        cnt_done = 1'b0; step(1'b1, "R4 sticky");
        cnt_start = 1'b0; step(1'b1, "R4 start fall keeps");
        cnt_start = 1'b1; step(1'b0, "R4 start rise clears");
        cnt_done = 1'b1; step(1'b1, "R4 done sets again");
        cnt_start = 1'b0; cnt_done = 1'b0; step(1'b1, "R4 hold");
        cnt_start = 1'b1; cnt_done = 1'b1; step(1'b0, "R4 clear wins");
        cnt_done = 1'b0; step(1'b0, "R4 stays clear");

        // R5: transfer clears flag
        cnt_done = 1'b1; step(1'b1, "R5 flag set");
        cnt_done = 1'b0; chip_en = 1'b1; xfer_out_mode = 1'b0;
        step(1'b0, "R8 receive overrides count");
        chip_en = 1'b0; step(1'b0, "R5 flag cleared by transfer");

        // R6 / R7: I/O mirrors
        sel_code = 3'd5; io_level = 2'b10; step(1'b1, "R6 io0 low");
        io_level = 2'b11; step(1'b0, "R6 io0 high");
        sel_code = 3'd6; io_level = 2'b01; step(1'b1, "R6 io1 low");
        io_level = 2'b11; step(1'b0, "R6 io1 high");
        io_level = 2'b00; io_is_out = 2'b01; sel_code = 3'd5;
        step(1'b0, "R7 io0 is output");
        sel_code = 3'd6; step(1'b1, "R6 io1 still input");
        io_is_out = 2'b10; step(1'b0, "R7 io1 is output");
        io_is_out = 2'b00; io_level = 2'b11;

        // R8: receive transfer releases
        sel_code = 3'd1; unlock = 1'b1; step(1'b1, "R3 before receive");
        chip_en = 1'b1; xfer_out_mode = 1'b0; step(1'b0, "R8 receive 1");
        ser_clk = 1'b1; step(1'b0, "R8 receive 2");
        ser_clk = 1'b0; chip_en = 1'b0; step(1'b1, "R8 after receive");

        // R9: transmit transfer
        chip_en = 1'b1; xfer_out_mode = 1'b1; step(1'b0, "R9 start released");
        shift_bit = 1'b0; ser_clk = 1'b1; step(1'b1, "R9 bit0 low");
        ser_clk = 1'b0; shift_bit = 1'b1; step(1'b1, "R9 hold without edge");
        ser_clk = 1'b1; step(1'b0, "R9 bit1 high");
        ser_clk = 1'b0; shift_bit = 1'b0; step(1'b0, "R9 hold");
        ser_clk = 1'b1; step(1'b1, "R9 bit0 again");
        ser_clk = 1'b0; chip_en = 1'b0; step(1'b1, "R9 end returns to unlock");
        chip_en = 1'b1; step(1'b0, "R9 new transfer released");
        chip_en = 1'b0; xfer_out_mode = 1'b0; step(1'b1, "R3 after transfer");

        while (sb_q.size() > 0) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule